// File: doc/BRIEF.md
# Paged Memory Mapper Register File

This block translates the upper address bits of an 8-bit CPU into a wider physical page number. Sixteen 12-bit page registers are held in one single-ported register file. When mapping is active, the four high CPU address bits pick a register, and its contents appear on a 12-bit mapped address output. The CPU can read and write the page registers through a 4-bit register-select port. The data path is split into an input bus, an output bus and an output-enable.

The register file has one address port only. While the chip-select is asserted, that port is steered to the register-select inputs, so the translation path then sees the selected register and not the page being mapped. A capture stage sits between the register file and the output. It is transparent while its enable is high and holds its value while the enable is low, so software can rewrite page registers without disturbing the translation on the output. A second control selects pass mode, where the raw page bits go to the top of the output with zeros below. A third control forces the whole output to zero.

Top module: `page_mapper`

## Requirements
- R1: After reset, page register i holds the value i (zero-extended to 12 bits), and the capture stage holds zero.
- R2: While `cs_n` is 0 and `rd_wr_n` is 1, `d_oe` is 1 and `d_out` equals the register selected by `rs`, within the same cycle.
- R3: When no read is in progress (`cs_n` is 1, or `rd_wr_n` is 0), `d_oe` is 0 and `d_out` is zero.
- R4: At a rising clock edge where `cs_n`, `rd_wr_n` and `strobe_n` are all 0, `d_in` is stored into the register selected by `rs`.
- R5: A write with `strobe_n` at 1, or with `cs_n` at 1, leaves every page register unchanged.
- R6: With `out_en_n`=0, `map_en_n`=0, `cap_en`=1 and `cs_n`=1, `mo` equals the register selected by `ma`, within the same cycle.
- R7: While `cap_en` is 0 in map mode, `mo` keeps the value present at the last rising edge where `cap_en` was 1, whatever `ma`, `rs`, `cs_n` or the register contents do.
- R8: While `cs_n` is 0 and `cap_en` is 1 in map mode, `mo` follows the register selected by `rs` and not the one selected by `ma`.
- R9: With `out_en_n`=0 and `map_en_n`=1 (pass mode), `mo[11:8]` equals `ma` and `mo[7:0]` is zero.
- R10: With `out_en_n`=1, `mo` is zero and `mo_valid` is 0. With `out_en_n`=0, `mo_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes and capture happen on the rising edge |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select for register access |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| strobe_n | input | 1 | Active-low write qualifier |
| map_en_n | input | 1 | Active-low map mode; 1 selects pass mode |
| out_en_n | input | 1 | Active-low enable for the mapped output |
| cap_en | input | 1 | Capture stage transparent when 1, holding when 0 |
| rs | input | 4 | Register select for CPU access |
| ma | input | 4 | Page bits from the CPU address |
| d_in | input | 12 | Write data |
| d_out | output | 12 | Read data, zero when not reading |
| d_oe | output | 1 | High during a valid read |
| mo | output | 12 | Mapped (or passed) address |
| mo_valid | output | 1 | High when the mapped output is enabled |

## Verification
The assertions assume that the inputs settle well before each rising edge. They also assume that the capture enable is treated as synchronous, so the held value is what the stage saw at an edge. The stimulus changes every input on the falling edge, then samples outputs two nanoseconds later, before the next rising edge. The bench updates its page model and held value only at rising edges. Random cycles mix reads, strobed and unstrobed writes, both modes and the output-enable freely. Directed cycles pin down reset contents, hold across register rewrites and the register-select steering of the map path.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam int PM_PAGE_BITS = 4;
   localparam int PM_WORD_W    = 12;

   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_MAP  = 2'd1,
      SRC_PASS = 2'd2
   } mo_src_e;
endpackage

// File: rtl/pm_regfile.sv
module pm_regfile #(
   parameter int PAGE_BITS = 4,
   parameter int WORD_W    = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PAGE_BITS-1:0] addr,
   input  logic                 we,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    rdata
);
   localparam int DEPTH = 1 << PAGE_BITS;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= WORD_W'(i);
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

   // R4: a strobed write is visible at the same address one cycle later
   a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/pm_hold_latch.sv
module pm_hold_latch #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  held <= '0;
      else if (en) held <= d;
   end

   assign q = en ? d : held;

   // R7: with the enable low for consecutive edges, the output does not move
   a_r7_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !$past(en)) |-> $stable(q));
endmodule

// File: rtl/pm_out_mux.sv
module pm_out_mux
   import pm_pkg::*;
#(
   parameter int PAGE_BITS = 4,
   parameter int WORD_W    = 12
) (
   input  logic                 out_en_n,
   input  logic                 map_en_n,
   input  logic [WORD_W-1:0]    mapped,
   input  logic [PAGE_BITS-1:0] page_in,
   output logic [WORD_W-1:0]    mo,
   output logic                 mo_valid
);
   localparam int LOW_W = WORD_W - PAGE_BITS;

   logic [WORD_W-1:0] pass_word;
   mo_src_e           src;

   generate
      if (LOW_W == 0) begin : g_pass_full
         assign pass_word = page_in;
      end else begin : g_pass_pad
         assign pass_word = {page_in, {LOW_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      if (out_en_n)      src = SRC_OFF;
      else if (map_en_n) src = SRC_PASS;
      else               src = SRC_MAP;
   end

   always_comb begin
      unique case (src)
         SRC_MAP:  mo = mapped;
         SRC_PASS: mo = pass_word;
         default:  mo = '0;
      endcase
   end

   assign mo_valid = (src != SRC_OFF);
endmodule

// File: rtl/page_mapper.sv
module page_mapper
   import pm_pkg::*;
#(
   parameter int PAGE_BITS = PM_PAGE_BITS,
   parameter int WORD_W    = PM_WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 rd_wr_n,
   input  logic                 strobe_n,
   input  logic                 map_en_n,
   input  logic                 out_en_n,
   input  logic                 cap_en,
   input  logic [PAGE_BITS-1:0] rs,
   input  logic [PAGE_BITS-1:0] ma,
   input  logic [WORD_W-1:0]    d_in,
   output logic [WORD_W-1:0]    d_out,
   output logic                 d_oe,
   output logic [WORD_W-1:0]    mo,
   output logic                 mo_valid
);
   generate
      if (PAGE_BITS < 1 || PAGE_BITS > 8) begin : g_bad_pages
         $error("page_mapper: PAGE_BITS must be 1..8");
      end
      if (WORD_W < PAGE_BITS) begin : g_bad_width
         $error("page_mapper: WORD_W must be at least PAGE_BITS");
      end
   endgenerate

   logic [PAGE_BITS-1:0] rf_addr;
   logic [WORD_W-1:0]    rf_rdata;
   logic [WORD_W-1:0]    cap_q;
   logic                 rd_act;
   logic                 wr_act;

   assign rf_addr = cs_n ? ma : rs;
   assign rd_act  = !cs_n && rd_wr_n;
   assign wr_act  = !cs_n && !rd_wr_n && !strobe_n;

   pm_regfile #(.PAGE_BITS(PAGE_BITS), .WORD_W(WORD_W)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (rf_addr),
      .we    (wr_act),
      .wdata (d_in),
      .rdata (rf_rdata)
   );

   pm_hold_latch #(.W(WORD_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cap_en),
      .d     (rf_rdata),
      .q     (cap_q)
   );

   pm_out_mux #(.PAGE_BITS(PAGE_BITS), .WORD_W(WORD_W)) u_mux (
      .out_en_n (out_en_n),
      .map_en_n (map_en_n),
      .mapped   (cap_q),
      .page_in  (ma),
      .mo       (mo),
      .mo_valid (mo_valid)
   );

   assign d_oe  = rd_act;
   assign d_out = rd_act ? rf_rdata : '0;

   // R3: the data bus stays quiet outside a read
   a_r3_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !rd_wr_n) |-> (d_out == '0 && !d_oe));

   // R8: during a read with a transparent capture stage, map output equals read data
   a_r8_rs_steers_map: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && rd_wr_n && cap_en && !out_en_n && !map_en_n) |-> (mo == d_out));

   // R9: pass mode puts the page bits on top
   a_r9_pass_top: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en_n && map_en_n) |-> (mo[WORD_W-1 -: PAGE_BITS] == ma && mo_valid));

   // R10: a disabled output is all zero and flagged invalid
   a_r10_output_off: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> (mo == '0 && !mo_valid));
endmodule

// File: tb/page_mapper_test.sv
module page_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_wr_n = 1'b1, strobe_n = 1'b1;
   logic        map_en_n = 1'b0, out_en_n = 1'b0, cap_en = 1'b1;
   logic [3:0]  rs = '0, ma = '0;
   logic [11:0] d_in = '0;
   logic [11:0] d_out, mo;
   logic        d_oe, mo_valid;

   int n_chk = 0;
   int n_bad = 0;

   logic [11:0] pages [16];
   logic [11:0] held;

   always #5 clk = ~clk;

   page_mapper uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr_n(rd_wr_n),
      .strobe_n(strobe_n), .map_en_n(map_en_n), .out_en_n(out_en_n),
      .cap_en(cap_en), .rs(rs), .ma(ma), .d_in(d_in),
      .d_out(d_out), .d_oe(d_oe), .mo(mo), .mo_valid(mo_valid)
   );

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] sel_word();
      return pages[cs_n ? ma : rs];
   endfunction

   function automatic logic [11:0] exp_mo();
      if (out_en_n) return '0;
      if (map_en_n) return {ma, 8'h00};
      return cap_en ? sel_word() : held;
   endfunction

   task automatic check_now();
      string tag;
      if (!cs_n && rd_wr_n) begin
         chk("R2 d_oe", {11'd0, d_oe}, 12'd1);
         chk("R2 d_out", d_out, pages[rs]);
      end else begin
         chk("R3 d_oe", {11'd0, d_oe}, 12'd0);
         chk("R3 d_out", d_out, 12'd0);
      end
      if (out_en_n)                 tag = "R10 mo";
      else if (map_en_n)            tag = "R9 mo";
      else if (!cap_en)             tag = "R7 mo";
      else if (!cs_n)               tag = "R8 mo";
      else                          tag = "R6 mo";
      chk(tag, mo, exp_mo());
      chk("R10 mo_valid", {11'd0, mo_valid}, {11'd0, !out_en_n});
   endtask

   // inputs already applied after a falling edge; check, then model the rising edge
   task automatic cycle();
      #2;
      check_now();
      @(posedge clk);
      if (cap_en) held = sel_word();
      if (!cs_n && !rd_wr_n && !strobe_n) pages[rs] = d_in;
      @(negedge clk);
   endtask

   task automatic set_in(input logic c, input logic r, input logic s,
                         input logic m, input logic o, input logic e,
                         input logic [3:0] r_s, input logic [3:0] m_a,
                         input logic [11:0] d);
      cs_n = c; rd_wr_n = r; strobe_n = s; map_en_n = m;
      out_en_n = o; cap_en = e; rs = r_s; ma = m_a; d_in = d;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      for (int i = 0; i < 16; i++) pages[i] = 12'(i);
      held = '0;
      repeat (3) @(negedge clk);
      // R1: capture stage cleared during reset (cap_en low shows held value)
      set_in(1, 1, 1, 0, 0, 0, 4'd0, 4'd9, '0);
      #1;
      chk("R1 held", mo, 12'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset contents read back
      for (int i = 0; i < 16; i++) begin
         set_in(0, 1, 1, 1, 1, 1, 4'(i), 4'(i), '0);
         #1;
         chk("R1 entry", d_out, 12'(i));
         cycle();
      end
      // R4: directed write then R5 blocked writes
      set_in(0, 0, 0, 0, 0, 1, 4'd5, 4'd0, 12'hABC); cycle();
      set_in(0, 0, 1, 0, 0, 1, 4'd5, 4'd0, 12'h111); cycle();  // R5 strobe high
      set_in(1, 0, 0, 0, 0, 1, 4'd5, 4'd0, 12'h222); cycle();  // R5 cs_n high
      set_in(0, 1, 1, 0, 0, 1, 4'd5, 4'd0, '0);
      #1;
      chk("R4/R5 readback", d_out, 12'hABC);
      cycle();
      // R6 then R7: capture page 5, rewrite it while held
      set_in(1, 1, 1, 0, 0, 1, 4'd0, 4'd5, '0); cycle();
      set_in(0, 0, 0, 0, 0, 0, 4'd5, 4'd2, 12'h777); cycle();
      set_in(1, 1, 1, 0, 0, 0, 4'd0, 4'd9, '0);
      #1;
      chk("R7 held across rewrite", mo, 12'hABC);
      cycle();
      // R8: access steers the map path to rs
      set_in(0, 1, 1, 0, 0, 1, 4'd5, 4'd9, '0);
      #1;
      chk("R8 rs steering", mo, 12'h777);
      cycle();
      // R9 corner: pass mode with all-ones page
      set_in(1, 1, 1, 1, 0, 1, 4'd0, 4'hF, '0);
      #1;
      chk("R9 pass ones", mo, 12'hF00);
      cycle();
      // random mix
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] r;
         r = $urandom();
         set_in(r[0] & r[1], r[2], r[3] & r[4], r[5] & r[6], r[7] & r[8] & r[9],
                r[10] | r[11], r[15:12], r[19:16], 12'($urandom()));
         cycle();
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule